// File: doc/BRIEF.md
# Delayed-Copy Edge Relationship Checker

This block is passive hardware assertion logic. It watches two single-bit control signals, a leader and a follower, and checks that the follower is the leader delayed by a fixed number of clock cycles. That number is set by the parameter `LATENCY`, which defaults to one. The block only samples the two signals and never drives them, so it can sit beside any functional sub-block without changing that block's behaviour.

Each clock edge, the checker compares the current sample of each signal with the sample before it to find edges. The leader's rising and falling edges go into a shift history that is `LATENCY` stages deep. The oldest history entry tells which follower edge is expected in the current sample. Rising-edge and falling-edge disagreements are reported on separate one-cycle error pulses. A missing follower edge and a stray follower edge are both treated as disagreements.

While `en_i` is low, both error outputs stay low and the history is cleared. The history is also empty after reset. In both cases checking starts again only once the history holds enough valid samples.

Top module: `edge_lag_checker`

## Requirements
- R1: When the follower equals the leader delayed by exactly `LATENCY` samples and checking is armed, both error outputs stay low.
- R2: A leader rising edge at sample k-`LATENCY` with no follower rising edge at sample k asserts `rise_err_o` for the single cycle after the clock edge that samples k. Here a rising edge at sample k means the value is 1 at k and 0 at k-1.
- R3: A leader falling edge at sample k-`LATENCY` with no follower falling edge at sample k asserts `fall_err_o` for the single cycle after the clock edge that samples k. Here a falling edge means the value is 0 at k and 1 at k-1.
- R4: A follower edge at sample k with no edge of the same kind on the leader at sample k-`LATENCY` asserts the matching error output, using the same timing as R2 and R3.
- R5: While `en_i` is low, both error outputs are low in the following cycle and the edge history is cleared. Sample k is checked only if `en_i` was high for samples k-`LATENCY` through k.
- R6: The first sample after reset produces no edge on either signal, so a signal that is already high when reset ends is not flagged.
- R7: The active-low asynchronous reset `rst_ni` clears both error outputs and all history.
- R8: Each error output is a registered pulse for one sample. Rising and falling mismatches are reported independently, and both outputs may be high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Checking enable; low clears history and silences the errors |
| lead_i | input | 1 | Leader signal being observed |
| follow_i | input | 1 | Follower signal expected to trail the leader by `LATENCY` cycles |
| rise_err_o | output | 1 | One-cycle pulse on a rising-edge mismatch |
| fall_err_o | output | 1 | One-cycle pulse on a falling-edge mismatch |

## Verification
The bench runs with a latency of two, so an off-by-one in the history depth shows up as errors on a correct stream or as silence on a skewed one. It drives a follower whose rise is late and whose fall is early, to catch a design that swaps or merges the two error outputs. It also drives stray and missing follower pulses, to catch a design that only looks for expected edges. It toggles both signals while disabled and right after re-enable, and releases reset with both signals high. A design that keeps stale history or treats the reset value as a real sample would report false errors there.

// File: rtl/edge_lag_pkg.sv
package edge_lag_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } elc_evt_t;

  localparam elc_evt_t ELC_NO_EVT = '{rise: 1'b0, fall: 1'b0};
endpackage

// File: rtl/elc_edge_detect.sv
module elc_edge_detect
  import edge_lag_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sig_i,
  output elc_evt_t evt_o,
  output logic     primed_o
);
  logic sig_q;
  logic primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      sig_q    <= sig_i;
      primed_q <= 1'b1;
    end
  end

  // no edge until a real previous sample exists
  always_comb begin
    evt_o = ELC_NO_EVT;
    if (primed_q) begin
      evt_o.rise = sig_i & ~sig_q;
      evt_o.fall = ~sig_i & sig_q;
    end
  end

  assign primed_o = primed_q;
endmodule

// File: rtl/elc_edge_history.sv
module elc_edge_history
  import edge_lag_pkg::*;
#(
  parameter int DEPTH = 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     ok_i,
  input  elc_evt_t evt_i,
  output elc_evt_t evt_o,
  output logic     valid_o
);
  elc_evt_t   stg_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q[0] <= ELC_NO_EVT;
      vld_q[0] <= 1'b0;
    end else if (!en_i) begin
      stg_q[0] <= ELC_NO_EVT;
      vld_q[0] <= 1'b0;
    end else begin
      stg_q[0] <= ok_i ? evt_i : ELC_NO_EVT;
      vld_q[0] <= ok_i;
    end
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[i] <= ELC_NO_EVT;
        vld_q[i] <= 1'b0;
      end else if (!en_i) begin
        stg_q[i] <= ELC_NO_EVT;
        vld_q[i] <= 1'b0;
      end else begin
        stg_q[i] <= stg_q[i-1];
        vld_q[i] <= vld_q[i-1];
      end
    end
  end

  assign evt_o   = stg_q[DEPTH-1];
  assign valid_o = vld_q[DEPTH-1];
endmodule

// File: rtl/elc_judge.sv
module elc_judge
  import edge_lag_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     arm_i,
  input  elc_evt_t exp_i,
  input  elc_evt_t obs_i,
  output logic     rise_err_o,
  output logic     fall_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_err_o <= 1'b0;
      fall_err_o <= 1'b0;
    end else begin
      rise_err_o <= arm_i & (exp_i.rise ^ obs_i.rise);
      fall_err_o <= arm_i & (exp_i.fall ^ obs_i.fall);
    end
  end
endmodule

// File: rtl/edge_lag_checker.sv
module edge_lag_checker
  import edge_lag_pkg::*;
#(
  parameter int LATENCY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lead_i,
  input  logic follow_i,
  output logic rise_err_o,
  output logic fall_err_o
);
  localparam int NSIG = 2;
  localparam int LEAD = 0;
  localparam int FOLW = 1;

  logic [NSIG-1:0] sig_w;
  logic [NSIG-1:0] primed_w;
  elc_evt_t        evt_w [NSIG];
  elc_evt_t        exp_w;
  logic            hist_vld;
  logic            arm;

  assign sig_w[LEAD] = lead_i;
  assign sig_w[FOLW] = follow_i;

  for (genvar s = 0; s < NSIG; s++) begin : g_det
    elc_edge_detect u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sig_i   (sig_w[s]),
      .evt_o   (evt_w[s]),
      .primed_o(primed_w[s])
    );
  end

  elc_edge_history #(.DEPTH(LATENCY)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .ok_i   (primed_w[LEAD]),
    .evt_i  (evt_w[LEAD]),
    .evt_o  (exp_w),
    .valid_o(hist_vld)
  );

  assign arm = en_i & hist_vld & primed_w[FOLW];

  elc_judge u_judge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .exp_i     (exp_w),
    .obs_i     (evt_w[FOLW]),
    .rise_err_o(rise_err_o),
    .fall_err_o(fall_err_o)
  );
endmodule

// File: rtl/elc_sva.sv
module elc_sva #(
  parameter int LATENCY = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic lead_i,
  input logic follow_i,
  input logic rise_err_o,
  input logic fall_err_o
);
  localparam int CAP = LATENCY + 1;
  localparam int RW  = $clog2(CAP + 1) + 1;

  logic [LATENCY:0] lead_d;
  logic             follow_q;
  logic [RW-1:0]    run_q;
  logic             armed;
  logic             exp_r, exp_f, obs_r, obs_f;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_d   <= '0;
      follow_q <= 1'b0;
      run_q    <= '0;
    end else begin
      lead_d   <= {lead_d[LATENCY-1:0], lead_i};
      follow_q <= follow_i;
      if (!en_i) run_q <= '0;
      else if (int'(run_q) < CAP) run_q <= run_q + 1'b1;
    end
  end

  assign armed = en_i && (int'(run_q) >= CAP);
  assign exp_r = lead_d[LATENCY-1] & ~lead_d[LATENCY];
  assign exp_f = ~lead_d[LATENCY-1] & lead_d[LATENCY];
  assign obs_r = follow_i & ~follow_q;
  assign obs_f = ~follow_i & follow_q;

  AST_MATCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && follow_i == lead_d[LATENCY-1] && follow_q == lead_d[LATENCY]) |=> (!rise_err_o && !fall_err_o)); // R1
  AST_RISE_MISSING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && exp_r && !obs_r) |=> rise_err_o); // R2
  AST_FALL_MISSING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && exp_f && !obs_f) |=> fall_err_o); // R3
  AST_RISE_STRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && obs_r && !exp_r) |=> rise_err_o); // R4
  AST_FALL_STRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && obs_f && !exp_f) |=> fall_err_o); // R4
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rise_err_o && !fall_err_o)); // R5

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_CLEAR: assert (!rise_err_o && !fall_err_o); // R7
    end
  end
endmodule

bind edge_lag_checker elc_sva #(.LATENCY(LATENCY)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .lead_i    (lead_i),
  .follow_i  (follow_i),
  .rise_err_o(rise_err_o),
  .fall_err_o(fall_err_o)
);

// File: tb/tb_edge_lag_checker.sv
`timescale 1ns/1ps
module tb_edge_lag_checker;
  localparam int LAT = 2;

  typedef struct {
    logic  rise;
    logic  fall;
    string tag;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic lead_i = 1'b0;
  logic follow_i = 1'b0;
  logic rise_err_o, fall_err_o;

  int checks = 0;
  int fails = 0;
  int k = -1;
  int run = 0;
  logic ld [8];
  logic fd [8];
  exp_t q [$];

  always #2 clk_i = ~clk_i;

  edge_lag_checker #(.LATENCY(LAT)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .lead_i(lead_i),
    .follow_i(follow_i), .rise_err_o(rise_err_o), .fall_err_o(fall_err_o)
  );

  // monitor: one expected item per sample
  initial begin
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (rise_err_o !== it.rise || fall_err_o !== it.fall) begin
          fails++;
          $display("FAIL %s: rise/fall=%b%b expected %b%b", it.tag,
                   rise_err_o, fall_err_o, it.rise, it.fall);
        end
      end
    end
  end

  task automatic step(input logic l, input logic f, input logic e, input string tag);
    exp_t it;
    logic chk, lr, lf, fr, ff;
    @(negedge clk_i);
    lead_i = l; follow_i = f; en_i = e;
    @(posedge clk_i);
    #1;
    for (int i = 7; i > 0; i--) begin
      ld[i] = ld[i-1];
      fd[i] = fd[i-1];
    end
    ld[0] = l; fd[0] = f;
    k++;
    run = e ? run + 1 : 0;
    chk = e && (run >= LAT + 1) && (k >= LAT + 1);
    lr = ld[LAT] & ~ld[LAT+1];
    lf = ~ld[LAT] & ld[LAT+1];
    fr = fd[0] & ~fd[1];
    ff = ~fd[0] & fd[1];
    it.rise = chk & (lr ^ fr);
    it.fall = chk & (lf ^ ff);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run_pat(input logic [23:0] l, input logic [23:0] f, input string tag);
    for (int i = 0; i < 24; i++) step(l[i], f[i], 1'b1, tag);
  endtask

  task automatic do_reset(input logic l, input logic f);
    @(negedge clk_i);
    #1;
    rst_ni = 1'b0; lead_i = l; follow_i = f; en_i = 1'b1;
    #9;
    checks++;
    if (rise_err_o !== 1'b0 || fall_err_o !== 1'b0) begin
      fails++;
      $display("FAIL R7: rise/fall=%b%b expected 00 in reset", rise_err_o, fall_err_o);
    end
    k = -1; run = 0;
    for (int i = 0; i < 8; i++) begin
      ld[i] = 1'b0;
      fd[i] = 1'b0;
    end
    @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0, 1'b0);
    // R1: correct copy, mixed pulse widths
    run_pat(24'h00B39A, 24'h00B39A << 2, "R1");
    run_pat(24'h0F0F01, 24'h0F0F01 << 2, "R1");
    // R2: late follower rise
    run_pat(24'h0000F0, 24'h000380, "R2");
    // R3: early follower fall
    run_pat(24'h0000F0, 24'h0001C0, "R3");
    // R4: stray follower pulse and missing follower pulse
    run_pat(24'h000000, 24'h000C00, "R4");
    run_pat(24'h000300, 24'h000000, "R4");
    // R8: both kinds in one sample, back-to-back
    run_pat(24'h0000AA, 24'h000055, "R8");
    // R5: disabled with garbage, then re-enabled
    for (int i = 0; i < 8; i++) step(i[0], ~i[1], 1'b0, "R5");
    step(1'b1, 1'b0, 1'b1, "R5");
    step(1'b0, 1'b1, 1'b1, "R5");
    run_pat(24'h00660C, 24'h00660C << 2, "R5");
    // R6/R7: reset release with both high
    do_reset(1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1, "R6");
    step(1'b1, 1'b1, 1'b1, "R6");
    run_pat(24'h0000F0, 24'h0003C3, "R6");
    // R7: reset mid-stream clears state
    step(1'b1, 1'b0, 1'b1, "R7");
    do_reset(1'b0, 1'b0);
    run_pat(24'h003030, 24'h003030 << 2, "R7");
    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule